// File: doc/BRIEF.md
# Store Ordering and Load Disambiguation Buffer

This block keeps every in-flight store in a circular queue, oldest first, and each cycle decides whether a candidate load may proceed past those stores. A store is allocated once. It then receives its address and its data as two separate events, in either order. Because the address can be known before the data, loads can be checked against it early. Stores are popped from the head only, and only once both halves are present.

A load arrives with its address and an age tag. The age tag is the store-queue tail pointer that was sampled when the load entered the pipeline. Only stores between the queue head and that tag count as older than the load. The block answers with one of three decisions: issue, block, or forward. On forward, it returns the data of the youngest older store whose address matches.

A mode input picks between two policies. The conservative policy holds a load back while any older store address is unresolved. The speculative policy assumes no aliasing, lets such loads proceed, and records each load that leaves in a small load table. Whenever a late store address resolves onto a younger recorded load, the block raises a violation that names the table slot, so that the pipeline can recover.

Top module: `ldst_order_buf`

## Requirements
- R1: After reset the store queue and load table are empty: `st_alloc_ready` is 1, `sq_tail` is 0, `viol_valid` is 0, and a load with age 0 gets decision issue. Decision codes: 0 issue, 1 block, 2 forward.
- R2: With `mode_spec`=0, a load is blocked whenever any store older than it has an unresolved address.
- R3: If the youngest older store with a matching address lacks data, the load is blocked. If that store has data, the decision is forward and `ld_fwd_data` carries that store's data in the same cycle.
- R4: `st_retire` removes the head store only when both its address and its data are present. Otherwise it has no effect, and that store keeps affecting loads.
- R5: A load issues when every older store has a known address that differs from the load address.
- R6: With `mode_spec`=1, stores with unresolved addresses are ignored by the decision.
- R7: A store is older than a load only if its position lies in the range from the queue head up to, but not including, the load's age tag. The age tag is a 4-bit pointer with a wrap bit in bit 3.
- R8: Addresses are compared as words: bits 1:0 are ignored, so any two byte addresses in the same 4-byte word alias.
- R9: With `mode_spec`=1, a store address resolution that matches a recorded load younger than that store raises `viol_valid` for one cycle, in the cycle after the resolution, with `viol_idx` giving the lowest matching slot.
- R10: When 8 stores are in flight, `st_alloc_ready` is 0 and an allocation request leaves `sq_tail` unchanged. Otherwise each allocation advances `sq_tail` by one.
- R11: With `mode_spec`=1, a load with `ld_valid` that is not blocked is recorded in the lowest free load-table slot, reported on `ld_slot`. While all 8 slots are held, loads are blocked. `lt_release` frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_spec | input | 1 | 1 selects the speculative policy, 0 the conservative one |
| st_alloc_valid | input | 1 | Allocate a store at the tail |
| st_alloc_ready | output | 1 | Queue has a free entry |
| sq_tail | output | 4 | Tail pointer with wrap bit; index of the next store and age tag for loads |
| sta_valid | input | 1 | Store address half arrives |
| sta_idx | input | 3 | Queue index of that store |
| sta_addr | input | 32 | Store byte address |
| std_valid | input | 1 | Store data half arrives |
| std_idx | input | 3 | Queue index of that store |
| std_data | input | 32 | Store data |
| st_retire | input | 1 | Request to pop the head store |
| ld_valid | input | 1 | Load actually proceeds this cycle (records it when not blocked) |
| ld_age | input | 4 | Load age tag (tail pointer sampled at load entry) |
| ld_addr | input | 32 | Load byte address |
| ld_decision | output | 2 | 0 issue, 1 block, 2 forward |
| ld_fwd_data | output | 32 | Forwarded store data |
| ld_slot | output | 3 | Load-table slot the load takes |
| lt_release | input | 1 | Free a load-table slot |
| lt_release_idx | input | 3 | Slot to free |
| viol_valid | output | 1 | Ordering violation pulse |
| viol_idx | output | 3 | Load-table slot of the violating load |

## Verification
The bench builds a queue that mixes complete stores, stores waiting for data and one store with no address. It then queries loads whose age tags cut that queue at different points. A wrong age window would forward from or block on a store that is younger than the load. A byte-granular compare would let a load at an offset in the same word issue past a data-less store.

Late address resolution is aimed at two recorded loads that share an address but sit on opposite sides of the resolving store. An age check with the wrong sense would flag the older load. Other corner cases covered are retire attempts on an incomplete head, which would wrongly drop a store, a full queue, which would overrun the tail, and a full load table, which would issue a load it cannot track.

// File: rtl/lsob_pkg.sv
package lsob_pkg;

    typedef enum logic [1:0] {
        DEC_ISSUE = 2'd0,
        DEC_BLOCK = 2'd1,
        DEC_FWD   = 2'd2
    } dec_e;

endpackage

// File: rtl/lsob_store_queue.sv
module lsob_store_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    output logic                       alloc_ready,
    output logic [PW-1:0]              head_ptr,
    output logic [PW-1:0]              tail_ptr,
    input  logic                       sta_valid,
    input  logic [IW-1:0]              sta_idx,
    input  logic [AW-1:0]              sta_addr,
    input  logic                       std_valid,
    input  logic [IW-1:0]              std_idx,
    input  logic [DW-1:0]              std_data,
    input  logic                       retire,
    output logic [DEPTH-1:0]           ent_vld,
    output logic [DEPTH-1:0]           ent_aok,
    output logic [DEPTH-1:0]           ent_dok,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [DEPTH-1:0][DW-1:0]   ent_data,
    output logic                       sta_fresh,
    output logic [PW-1:0]              sta_ptr
);

    typedef struct packed {
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0]         aok;
        logic [DEPTH-1:0]         dok;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
    } sq_state_t;

    sq_state_t s_d, s_q;
    logic [PW-1:0] occ;
    logic          full;
    logic [IW-1:0] hidx;
    logic [IW-1:0] tidx;

    always_comb begin
        s_d  = s_q;
        occ  = s_q.tail - s_q.head;
        full = occ[IW];
        hidx = s_q.head[IW-1:0];
        tidx = s_q.tail[IW-1:0];

        if (alloc_valid && !full) begin
            s_d.vld[tidx] = 1'b1;
            s_d.aok[tidx] = 1'b0;
            s_d.dok[tidx] = 1'b0;
            s_d.tail      = s_q.tail + PW'(1);
        end
        if (sta_valid && s_q.vld[sta_idx]) begin
            s_d.aok[sta_idx]  = 1'b1;
            s_d.addr[sta_idx] = sta_addr;
        end
        if (std_valid && s_q.vld[std_idx]) begin
            s_d.dok[std_idx]  = 1'b1;
            s_d.data[std_idx] = std_data;
        end
        // only a complete head store may leave: strict program order
        if (retire && s_q.vld[hidx] && s_q.aok[hidx] && s_q.dok[hidx]) begin
            s_d.vld[hidx] = 1'b0;
            s_d.head      = s_q.head + PW'(1);
        end

        sta_fresh = sta_valid && s_q.vld[sta_idx] && !s_q.aok[sta_idx];
        sta_ptr   = {(sta_idx >= hidx) ? s_q.head[IW] : ~s_q.head[IW], sta_idx};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alloc_ready = !full;
    assign head_ptr    = s_q.head;
    assign tail_ptr    = s_q.tail;
    assign ent_vld     = s_q.vld;
    assign ent_aok     = s_q.aok;
    assign ent_dok     = s_q.dok;
    assign ent_addr    = s_q.addr;
    assign ent_data    = s_q.data;

endmodule

// File: rtl/lsob_order_check.sv
module lsob_order_check
    import lsob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1,
    localparam logic [AW-1:0] WMASK = {{(AW-2){1'b1}}, 2'b00}
) (
    input  logic                     mode_spec,
    input  logic                     lt_full,
    input  logic [PW-1:0]            head_ptr,
    input  logic [PW-1:0]            ld_age,
    input  logic [AW-1:0]            ld_addr,
    input  logic [DEPTH-1:0]         ent_vld,
    input  logic [DEPTH-1:0]         ent_aok,
    input  logic [DEPTH-1:0]         ent_dok,
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    output dec_e                     dec,
    output logic [DW-1:0]            fwd_data
);

    logic [PW-1:0] span;
    logic [IW-1:0] idx;
    logic          unknown_older;
    logic          hit;
    logic          hit_dok;
    logic [DW-1:0] hit_data;

    always_comb begin
        span          = ld_age - head_ptr;
        unknown_older = 1'b0;
        hit           = 1'b0;
        hit_dok       = 1'b0;
        hit_data      = '0;
        idx           = '0;
        // walk oldest to youngest so the last match is the youngest
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr[IW-1:0] + IW'(k);
            if (k < int'(span) && ent_vld[idx]) begin
                if (!ent_aok[idx]) begin
                    unknown_older = 1'b1;
                end else if (((ent_addr[idx] ^ ld_addr) & WMASK) == '0) begin
                    hit      = 1'b1;
                    hit_dok  = ent_dok[idx];
                    hit_data = ent_data[idx];
                end
            end
        end

        if (!mode_spec && unknown_older)  dec = DEC_BLOCK;
        else if (hit && !hit_dok)         dec = DEC_BLOCK;
        else if (mode_spec && lt_full)    dec = DEC_BLOCK;
        else if (hit)                     dec = DEC_FWD;
        else                              dec = DEC_ISSUE;
        fwd_data = hit_data;
    end

endmodule

// File: rtl/lsob_load_table.sv
module lsob_load_table #(
    parameter int LT_DEPTH = 8,
    parameter int SQ_DEPTH = 8,
    parameter int AW       = 32,
    localparam int LW      = $clog2(LT_DEPTH),
    localparam int PW      = $clog2(SQ_DEPTH) + 1,
    localparam logic [AW-1:0] WMASK = {{(AW-2){1'b1}}, 2'b00}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_valid,
    input  logic [PW-1:0] rec_age,
    input  logic [AW-1:0] rec_addr,
    input  logic          rel_valid,
    input  logic [LW-1:0] rel_idx,
    input  logic          chk_valid,
    input  logic [PW-1:0] chk_ptr,
    input  logic [AW-1:0] chk_addr,
    output logic          full,
    output logic [LW-1:0] rec_slot,
    output logic          viol_valid,
    output logic [LW-1:0] viol_idx
);

    typedef struct packed {
        logic [LT_DEPTH-1:0]         vld;
        logic [LT_DEPTH-1:0][PW-1:0] age;
        logic [LT_DEPTH-1:0][AW-1:0] addr;
        logic                        viol_v;
        logic [LW-1:0]               viol_i;
    } lt_state_t;

    lt_state_t     s_d, s_q;
    logic [LW-1:0] slot;
    logic          rec_go;
    logic          e_new;
    logic          e_vld;
    logic [PW-1:0] e_age;
    logic [AW-1:0] e_addr;
    logic [PW-1:0] gap;

    always_comb begin
        s_d  = s_q;
        full = &s_q.vld;
        slot = '0;
        for (int j = LT_DEPTH - 1; j >= 0; j--) begin
            if (!s_q.vld[j]) slot = LW'(j);
        end
        rec_go = rec_valid && !full;

        if (rel_valid) s_d.vld[rel_idx] = 1'b0;
        if (rec_go) begin
            s_d.vld[slot]  = 1'b1;
            s_d.age[slot]  = rec_age;
            s_d.addr[slot] = rec_addr;
        end

        // compare the resolving store against every load held after this
        // cycle, including one being recorded right now
        s_d.viol_v = 1'b0;
        s_d.viol_i = '0;
        e_new  = 1'b0;
        e_vld  = 1'b0;
        e_age  = '0;
        e_addr = '0;
        gap    = '0;
        for (int j = LT_DEPTH - 1; j >= 0; j--) begin
            e_new  = rec_go && (slot == LW'(j));
            e_vld  = e_new || (s_q.vld[j] && !(rel_valid && rel_idx == LW'(j)));
            e_age  = e_new ? rec_age : s_q.age[j];
            e_addr = e_new ? rec_addr : s_q.addr[j];
            gap    = e_age - chk_ptr;
            if (chk_valid && e_vld && gap != '0 && int'(gap) <= SQ_DEPTH
                && ((e_addr ^ chk_addr) & WMASK) == '0) begin
                s_d.viol_v = 1'b1;
                s_d.viol_i = LW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rec_slot   = slot;
    assign viol_valid = s_q.viol_v;
    assign viol_idx   = s_q.viol_i;

endmodule

// File: rtl/ldst_order_buf.sv
module ldst_order_buf
    import lsob_pkg::*;
#(
    parameter int SQ_DEPTH = 8,
    parameter int LT_DEPTH = 8,
    parameter int AW       = 32,
    parameter int DW       = 32,
    localparam int IW      = $clog2(SQ_DEPTH),
    localparam int PW      = IW + 1,
    localparam int LW      = $clog2(LT_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_spec,
    input  logic          st_alloc_valid,
    output logic          st_alloc_ready,
    output logic [PW-1:0] sq_tail,
    input  logic          sta_valid,
    input  logic [IW-1:0] sta_idx,
    input  logic [AW-1:0] sta_addr,
    input  logic          std_valid,
    input  logic [IW-1:0] std_idx,
    input  logic [DW-1:0] std_data,
    input  logic          st_retire,
    input  logic          ld_valid,
    input  logic [PW-1:0] ld_age,
    input  logic [AW-1:0] ld_addr,
    output logic [1:0]    ld_decision,
    output logic [DW-1:0] ld_fwd_data,
    output logic [LW-1:0] ld_slot,
    input  logic          lt_release,
    input  logic [LW-1:0] lt_release_idx,
    output logic          viol_valid,
    output logic [LW-1:0] viol_idx
);

    logic [PW-1:0]               head_ptr;
    logic [SQ_DEPTH-1:0]         ent_vld, ent_aok, ent_dok;
    logic [SQ_DEPTH-1:0][AW-1:0] ent_addr;
    logic [SQ_DEPTH-1:0][DW-1:0] ent_data;
    logic                        sta_fresh;
    logic [PW-1:0]               sta_ptr;
    logic                        lt_full;
    dec_e                        dec;
    logic                        rec_valid;

    lsob_store_queue #(.DEPTH(SQ_DEPTH), .AW(AW), .DW(DW)) u_sq (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (st_alloc_valid),
        .alloc_ready (st_alloc_ready),
        .head_ptr    (head_ptr),
        .tail_ptr    (sq_tail),
        .sta_valid   (sta_valid),
        .sta_idx     (sta_idx),
        .sta_addr    (sta_addr),
        .std_valid   (std_valid),
        .std_idx     (std_idx),
        .std_data    (std_data),
        .retire      (st_retire),
        .ent_vld     (ent_vld),
        .ent_aok     (ent_aok),
        .ent_dok     (ent_dok),
        .ent_addr    (ent_addr),
        .ent_data    (ent_data),
        .sta_fresh   (sta_fresh),
        .sta_ptr     (sta_ptr)
    );

    lsob_order_check #(.DEPTH(SQ_DEPTH), .AW(AW), .DW(DW)) u_chk_ord (
        .mode_spec (mode_spec),
        .lt_full   (lt_full),
        .head_ptr  (head_ptr),
        .ld_age    (ld_age),
        .ld_addr   (ld_addr),
        .ent_vld   (ent_vld),
        .ent_aok   (ent_aok),
        .ent_dok   (ent_dok),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .dec       (dec),
        .fwd_data  (ld_fwd_data)
    );

    assign rec_valid   = mode_spec && ld_valid && (dec != DEC_BLOCK);
    assign ld_decision = dec;

    lsob_load_table #(.LT_DEPTH(LT_DEPTH), .SQ_DEPTH(SQ_DEPTH), .AW(AW)) u_lt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_valid  (rec_valid),
        .rec_age    (ld_age),
        .rec_addr   (ld_addr),
        .rel_valid  (lt_release),
        .rel_idx    (lt_release_idx),
        .chk_valid  (mode_spec && sta_fresh),
        .chk_ptr    (sta_ptr),
        .chk_addr   (sta_addr),
        .full       (lt_full),
        .rec_slot   (ld_slot),
        .viol_valid (viol_valid),
        .viol_idx   (viol_idx)
    );

endmodule

// File: rtl/lsob_checker.sv
module lsob_checker #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_spec,
    input logic          st_alloc_valid,
    input logic          st_alloc_ready,
    input logic [PW-1:0] sq_tail,
    input logic          sta_valid,
    input logic          viol_valid,
    input logic [1:0]    ld_decision
);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_alloc_ready && sq_tail == '0 && !viol_valid));

    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_alloc_ready |=> sq_tail == $past(sq_tail));

    assert_tail_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_alloc_valid && st_alloc_ready) |=> sq_tail == ($past(sq_tail) + PW'(1)));

    assert_viol_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(sta_valid && mode_spec));

    assert_dec_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_decision != 2'd3);

endmodule

bind ldst_order_buf lsob_checker #(.PW(PW)) u_lsob_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_spec      (mode_spec),
    .st_alloc_valid (st_alloc_valid),
    .st_alloc_ready (st_alloc_ready),
    .sq_tail        (sq_tail),
    .sta_valid      (sta_valid),
    .viol_valid     (viol_valid),
    .ld_decision    (ld_decision)
);

// File: tb/ldst_order_buf_tb.sv
`timescale 1ns/1ps
module ldst_order_buf_tb;

    localparam int D_ISSUE = 0;
    localparam int D_BLOCK = 1;
    localparam int D_FWD   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_spec = 1'b0;
    logic        st_alloc_valid = 1'b0;
    logic        st_alloc_ready;
    logic [3:0]  sq_tail;
    logic        sta_valid = 1'b0;
    logic [2:0]  sta_idx = '0;
    logic [31:0] sta_addr = '0;
    logic        std_valid = 1'b0;
    logic [2:0]  std_idx = '0;
    logic [31:0] std_data = '0;
    logic        st_retire = 1'b0;
    logic        ld_valid = 1'b0;
    logic [3:0]  ld_age = '0;
    logic [31:0] ld_addr = '0;
    logic [1:0]  ld_decision;
    logic [31:0] ld_fwd_data;
    logic [2:0]  ld_slot;
    logic        lt_release = 1'b0;
    logic [2:0]  lt_release_idx = '0;
    logic        viol_valid;
    logic [2:0]  viol_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ldst_order_buf u_dut (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic        spec;
        logic [3:0]  age;
        logic [31:0] addr;
        logic [1:0]  dec;
        logic [31:0] data;
    } vec_t;

    // queue: s0 0x100/A0, s1 0x200/no data, s2 no address, s3 0x104/D3
    localparam vec_t VECS [12] = '{
        '{4'd2,  1'b0, 4'd4, 32'h300, 2'd1, 32'h0},   // R2 unknown older blocks
        '{4'd6,  1'b1, 4'd4, 32'h300, 2'd0, 32'h0},   // R6 speculative ignores it
        '{4'd5,  1'b0, 4'd2, 32'h300, 2'd0, 32'h0},   // R5 known, no match
        '{4'd3,  1'b0, 4'd2, 32'h100, 2'd2, 32'hA0},  // R3 forward
        '{4'd3,  1'b0, 4'd2, 32'h200, 2'd1, 32'h0},   // R3 match without data
        '{4'd8,  1'b0, 4'd2, 32'h203, 2'd1, 32'h0},   // R8 same word
        '{4'd7,  1'b0, 4'd1, 32'h200, 2'd0, 32'h0},   // R7 s1 not older
        '{4'd3,  1'b1, 4'd4, 32'h104, 2'd2, 32'hD3},  // R3 youngest match
        '{4'd3,  1'b1, 4'd4, 32'h200, 2'd1, 32'h0},   // R3 spec, no data
        '{4'd3,  1'b1, 4'd4, 32'h100, 2'd2, 32'hA0},  // R3 spec forward
        '{4'd7,  1'b0, 4'd0, 32'h100, 2'd0, 32'h0},   // R7 nothing older
        '{4'd8,  1'b1, 4'd4, 32'h204, 2'd0, 32'h0}    // R8 next word differs
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc();
        st_alloc_valid = 1'b1;
        step();
        st_alloc_valid = 1'b0;
    endtask

    task automatic do_sta(input logic [2:0] i, input logic [31:0] a);
        sta_idx = i; sta_addr = a; sta_valid = 1'b1;
        step();
        sta_valid = 1'b0;
    endtask

    task automatic do_std(input logic [2:0] i, input logic [31:0] d);
        std_idx = i; std_data = d; std_valid = 1'b1;
        step();
        std_valid = 1'b0;
    endtask

    task automatic query(input logic spec, input logic [3:0] age, input logic [31:0] a);
        mode_spec = spec; ld_age = age; ld_addr = a;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        query(1'b0, 4'd0, 32'h100);
        chk("R1 ready", 32'(st_alloc_ready), 32'd1);
        chk("R1 tail", 32'(sq_tail), 32'd0);
        chk("R1 viol", 32'(viol_valid), 32'd0);
        chk("R1 decision", 32'(ld_decision), D_ISSUE);

        for (int i = 0; i < 4; i++) do_alloc();
        chk("R10 tail after four", 32'(sq_tail), 32'd4);
        do_sta(3'd0, 32'h100);
        do_std(3'd0, 32'hA0);
        do_sta(3'd1, 32'h200);
        do_std(3'd3, 32'hD3);
        do_sta(3'd3, 32'h104);

        for (int v = 0; v < 12; v++) begin
            query(VECS[v].spec, VECS[v].age, VECS[v].addr);
            chk($sformatf("R%0d vec%0d decision", VECS[v].req, v),
                32'(ld_decision), 32'(VECS[v].dec));
            if (VECS[v].dec == 2'd2)
                chk($sformatf("R%0d vec%0d data", VECS[v].req, v), ld_fwd_data, VECS[v].data);
        end

        // R9: speculative load passes unknown s2, then s2 resolves onto it
        query(1'b1, 4'd4, 32'h300);
        ld_valid = 1'b1; #1;
        chk("R11 slot A", 32'(ld_slot), 32'd0);
        step();
        ld_valid = 1'b0;
        do_sta(3'd2, 32'h300);
        chk("R9 pulse", 32'(viol_valid), 32'd1);
        chk("R9 idx", 32'(viol_idx), 32'd0);
        step();
        chk("R9 one cycle", 32'(viol_valid), 32'd0);

        // R9/R7: two loads on either side of a new store s4
        do_alloc();
        query(1'b1, 4'd4, 32'h500);
        ld_valid = 1'b1; #1;
        chk("R11 slot B", 32'(ld_slot), 32'd1);
        step();
        query(1'b1, 4'd5, 32'h500); #1;
        chk("R6 load C issue", 32'(ld_decision), D_ISSUE);
        chk("R11 slot C", 32'(ld_slot), 32'd2);
        step();
        ld_valid = 1'b0;
        do_sta(3'd4, 32'h502);
        chk("R9 younger only", 32'(viol_valid), 32'd1);
        chk("R9 younger idx", 32'(viol_idx), 32'd2);

        // R4: in-order retire gated on completion
        st_retire = 1'b1; step(); st_retire = 1'b0;
        query(1'b1, 4'd5, 32'h100);
        chk("R4 head popped", 32'(ld_decision), D_ISSUE);
        st_retire = 1'b1; step(); st_retire = 1'b0;
        query(1'b1, 4'd5, 32'h200);
        chk("R4 incomplete kept", 32'(ld_decision), D_BLOCK);
        do_std(3'd1, 32'hB1);
        query(1'b1, 4'd5, 32'h200);
        chk("R3 late data fwd", 32'(ld_decision), D_FWD);
        chk("R3 late data value", ld_fwd_data, 32'hB1);
        st_retire = 1'b1; step(); st_retire = 1'b0;
        query(1'b1, 4'd5, 32'h200);
        chk("R4 second pop", 32'(ld_decision), D_ISSUE);

        // R10: fill the queue (3 held, add 5)
        for (int i = 0; i < 5; i++) do_alloc();
        chk("R10 full ready", 32'(st_alloc_ready), 32'd0);
        do_alloc();
        chk("R10 tail held", 32'(sq_tail), 32'd10);

        // R11: fill the load table with loads that have nothing older
        query(1'b1, 4'd2, 32'h600);
        ld_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk("R11 fill slot", 32'(ld_slot), 32'(3 + i));
            step();
        end
        ld_valid = 1'b0;
        query(1'b1, 4'd2, 32'h600);
        chk("R11 table full blocks", 32'(ld_decision), D_BLOCK);
        lt_release_idx = 3'd5; lt_release = 1'b1; step(); lt_release = 1'b0;
        query(1'b1, 4'd2, 32'h600);
        chk("R11 after release", 32'(ld_decision), D_ISSUE);
        chk("R11 freed slot", 32'(ld_slot), 32'd5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule